// File: doc/BRIEF.md
# Keyed-Restart Watchdog Countdown Timer

This block is a watchdog timer behind a simple 32-bit register port. Software loads a reload value and sets the enable bit; the block then counts down, either on every clock cycle or only on a one-microsecond tick pulse. Software keeps the system alive by writing a 16-bit key to the restart register, which reloads the counter. If the count runs down to zero, the block raises a reset request and an interrupt, each one gated by its own control bit.

A bypass input covers the case where the memory controller is itself being reset. If the count expires while the bypass is high, the block issues no request and clears its whole control register, so the watchdog ends up disabled. Accesses to offsets outside the four implemented registers, and accesses that are not word aligned, read as zero and have no effect.

Top module: `wdog_timer`

## Requirements
- R1: After reset the live counter and the reload register both read 0x014FB180, the control register reads 0, and rst_req, rst_sticky and irq are low.
- R2: Offset 0x04 (reload) reads back what was written to it. Offset 0x0C (control) stores the written value with bits [9:7] forced to 0. Read data appears on rdata in the cycle after rd_en.
- R3: A write to offset 0x08 whose low 16 bits equal 0x4755 loads the counter from the reload register. A write with any other value leaves the counter unchanged. Offset 0x08 reads as 0.
- R4: Writing control bit 0 = 1 while bit 0 is clear loads the counter from the reload register and starts the countdown. The same edge clears rst_sticky and irq.
- R5: Writing control bit 0 = 0 stops the countdown, and the counter then holds its value.
- R6: With control bit 4 = 1, the counter decrements once per clock cycle in which tick_1us is high. With bit 4 = 0, it decrements on every clock cycle.
- R7: On the decrement from 1 to 0 with mem_bypass low and control bit 1 set, rst_req is high for exactly one cycle, starting in the cycle where the counter first reads 0, and rst_sticky rises with it. The counter stays at 0 and does not wrap.
- R8: On the same expiry with control bit 2 set, irq rises and stays high until the next enable rising edge. rst_req stays low when control bit 1 is clear.
- R9: If the counter expires while mem_bypass is high, the control register becomes 0 and rst_req, rst_sticky and irq stay low.
- R10: Writes to offset 0x00 (counter, read-only) are ignored. Unknown or unaligned offsets read 0 and ignore writes.
- R11: In any cycle that carries a write to offset 0x08 or 0x0C, the counter does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| tick_1us | input | 1 | One-cycle pulse each microsecond |
| mem_bypass | input | 1 | Memory-controller-reset bypass; blocks expiry action |
| rst_req | output | 1 | One-cycle reset request pulse |
| rst_sticky | output | 1 | Reset request seen since last enable edge |
| irq | output | 1 | Level timeout interrupt |

## Verification
A write issued before clock edge E takes effect at E. In clock mode, a counter loaded with N reaches zero at edge E+N. rst_req, rst_sticky and irq change at that same edge, so the bench samples them on the falling edge after E+N-1 (expected low) and after E+N (expected at their new values). Read data is registered, so the driver queues each expected value when it raises rd_en, and the monitor compares it on the falling edge after the capturing edge. Whenever the bench reads the counter, it has frozen the count first, either in tick mode with no ticks or by disabling the watchdog, so the value is fixed.

// File: rtl/wdog_pkg.sv
// Shared constants for the watchdog: register offsets, restart key,
// control-bit positions and reset values. Assumes a 32-bit data path.
package wdog_pkg;
    localparam int DATA_W = 32;
    localparam logic [7:0] OFF_COUNT   = 8'h00;
    localparam logic [7:0] OFF_RELOAD  = 8'h04;
    localparam logic [7:0] OFF_RESTART = 8'h08;
    localparam logic [7:0] OFF_CTRL    = 8'h0C;
    localparam logic [15:0] RESTART_KEY = 16'h4755;
    localparam logic [DATA_W-1:0] CNT_RST_VAL = 32'h014F_B180;
    localparam logic [DATA_W-1:0] CTRL_CLR_MASK = 32'h0000_0380;
    localparam int B_EN      = 0;
    localparam int B_SYSRST  = 1;
    localparam int B_IRQ     = 2;
    localparam int B_TICKSEL = 4;
endpackage

// File: rtl/wdog_counter.sv
// Down-counter: loads on request, steps on the selected source, saturates
// at zero and flags the 1->0 step. Assumes load and freeze come from the
// register block in the same cycle as the bus write.
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int W = DATA_W,
    parameter logic [W-1:0] RST_VAL = CNT_RST_VAL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick_sel,
    input  logic         tick_1us,
    input  logic         freeze,
    output logic [W-1:0] count,
    output logic         expire_evt
);
    logic step;

    // Decide whether this cycle decrements the count
    always_comb begin
        step       = run && !freeze && (tick_sel ? tick_1us : 1'b1) && (count != '0);
        expire_evt = step && (count == W'(1));
    end

    // Count register: load wins over a step
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= RST_VAL;
        else if (load)  count <= load_val;
        else if (step)  count <= count - W'(1);
    end

    // R5
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));
    // R7
    zero_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load) |=> (count == '0));
    // R11
    freeze_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !load) |=> $stable(count));
endmodule

// File: rtl/wdog_regs.sv
// Register block: decodes aligned word accesses, keeps reload and control,
// checks the restart key and detects enable edges. Read data is registered.
// Assumes one access per cycle; unaligned or unknown offsets are no-ops.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      count,
    input  logic              expire_evt,
    input  logic              mem_bypass,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      reload_q,
    output logic              en,
    output logic              tick_sel,
    output logic              sysrst_en,
    output logic              irq_en,
    output logic              load_cnt,
    output logic              en_rise,
    output logic              freeze
);
    logic [W-1:0] ctrl_q;
    logic         wr_ok, wr_ctrl, wr_restart, key_ok;

    // Decode the write strobe into per-register actions
    always_comb begin
        wr_ok      = wr_en && (addr[1:0] == 2'b00);
        wr_ctrl    = wr_ok && (addr == ADDR_W'(OFF_CTRL));
        wr_restart = wr_ok && (addr == ADDR_W'(OFF_RESTART));
        key_ok     = wr_restart && (wdata[15:0] == RESTART_KEY);
        en_rise    = wr_ctrl && wdata[B_EN] && !ctrl_q[B_EN];
        load_cnt   = key_ok || en_rise;
        freeze     = wr_ctrl || wr_restart;
        en         = ctrl_q[B_EN];
        tick_sel   = ctrl_q[B_TICKSEL];
        sysrst_en  = ctrl_q[B_SYSRST];
        irq_en     = ctrl_q[B_IRQ];
    end

    // Reload register
    always_ff @(posedge clk) begin
        if (!rst_n) reload_q <= CNT_RST_VAL;
        else if (wr_ok && addr == ADDR_W'(OFF_RELOAD)) reload_q <= wdata;
    end

    // Control register: cleaned bus write, or full clear on bypassed expiry
    always_ff @(posedge clk) begin
        if (!rst_n)                        ctrl_q <= '0;
        else if (wr_ctrl)                  ctrl_q <= wdata & ~CTRL_CLR_MASK;
        else if (expire_evt && mem_bypass) ctrl_q <= '0;
    end

    // Registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            case (addr)
                ADDR_W'(OFF_COUNT):  rdata <= count;
                ADDR_W'(OFF_RELOAD): rdata <= reload_q;
                ADDR_W'(OFF_CTRL):   rdata <= ctrl_q;
                default:             rdata <= '0;
            endcase
        end
    end

    // R9
    bypass_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_evt && mem_bypass) |=> (ctrl_q == '0));
    // R2
    ctrl_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q[9:7] == 3'b000));
endmodule

// File: rtl/wdog_expiry.sv
// Expiry handling: turns the 1->0 event into a one-cycle reset request,
// a sticky flag and a level interrupt, each qualified by its control bit
// and blocked by the bypass input. Flags clear on an enable rising edge.
module wdog_expiry (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_evt,
    input  logic mem_bypass,
    input  logic en_rise,
    input  logic sysrst_en,
    input  logic irq_en,
    output logic rst_req,
    output logic rst_sticky,
    output logic irq
);
    logic fire;

    // Expiry that is allowed to act
    always_comb fire = expire_evt && !mem_bypass;

    // Single-cycle reset request
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= fire && sysrst_en;
    end

    // Sticky request flag and level interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_sticky <= 1'b0;
            irq        <= 1'b0;
        end else if (en_rise) begin
            rst_sticky <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (fire && sysrst_en) rst_sticky <= 1'b1;
            if (fire && irq_en)    irq        <= 1'b1;
        end
    end

    // R7
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R7
    req_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> rst_sticky);
    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !en_rise) |=> irq);
    // R9
    bypass_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_evt && mem_bypass) |=> !rst_req);
endmodule

// File: rtl/wdog_timer.sv
// Top of the watchdog: register block, down-counter and expiry handler.
// Assumes tick_1us is a single-cycle pulse synchronous to clk.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_1us,
    input  logic              mem_bypass,
    output logic              rst_req,
    output logic              rst_sticky,
    output logic              irq
);
    logic [DATA_W-1:0] count, reload_q;
    logic en, tick_sel, sysrst_en, irq_en, load_cnt, en_rise, freeze, expire_evt;

    wdog_regs #(.ADDR_W(ADDR_W), .W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .count(count), .expire_evt(expire_evt),
        .mem_bypass(mem_bypass), .rdata(rdata), .reload_q(reload_q), .en(en),
        .tick_sel(tick_sel), .sysrst_en(sysrst_en), .irq_en(irq_en),
        .load_cnt(load_cnt), .en_rise(en_rise), .freeze(freeze)
    );

    wdog_counter #(.W(DATA_W), .RST_VAL(CNT_RST_VAL)) u_counter (
        .clk(clk), .rst_n(rst_n), .load(load_cnt), .load_val(reload_q),
        .run(en), .tick_sel(tick_sel), .tick_1us(tick_1us), .freeze(freeze),
        .count(count), .expire_evt(expire_evt)
    );

    wdog_expiry u_expiry (
        .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt),
        .mem_bypass(mem_bypass), .en_rise(en_rise), .sysrst_en(sysrst_en),
        .irq_en(irq_en), .rst_req(rst_req), .rst_sticky(rst_sticky), .irq(irq)
    );
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_1us = 1'b0, mem_bypass = 1'b0;
    logic        rst_req, rst_sticky, irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        done = 1'b0;

    always #2 clk = ~clk;

    wdog_timer u_wdog_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_1us(tick_1us),
        .mem_bypass(mem_bypass), .rst_req(rst_req), .rst_sticky(rst_sticky),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: issue the read and queue its expected result
    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick_pulse();
        tick_1us = 1'b1;
        @(negedge clk);
        tick_1us = 1'b0;
    endtask

    // Monitor: compare read data on the falling edge after capture
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) check("monitor: unexpected read", 32'h1, 32'h0);
                else check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 rst_req", {31'b0, rst_req}, 32'h0);
        check("R1 rst_sticky", {31'b0, rst_sticky}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        bus_rd(8'h00, 32'h014F_B180, "R1 counter");
        bus_rd(8'h04, 32'h014F_B180, "R1 reload");
        bus_rd(8'h0C, 32'h0, "R1 control");

        // R2 reload and cleaned control
        bus_wr(8'h04, 32'h1234_5678);
        bus_rd(8'h04, 32'h1234_5678, "R2 reload readback");
        bus_wr(8'h0C, 32'hFFFF_FFFE);
        bus_rd(8'h0C, 32'hFFFF_FC7E, "R2 control bits 9:7 cleared");
        bus_wr(8'h0C, 32'h0);

        // R10 read-only, unknown, unaligned
        bus_wr(8'h00, 32'h0000_DEAD);
        bus_rd(8'h00, 32'h014F_B180, "R10 counter write ignored");
        bus_wr(8'h20, 32'hCAFE_F00D);
        bus_rd(8'h20, 32'h0, "R10 unknown offset reads 0");
        bus_wr(8'h05, 32'h0000_0077);
        bus_rd(8'h04, 32'h1234_5678, "R10 unaligned write ignored");
        bus_rd(8'h06, 32'h0, "R10 unaligned read 0");
        bus_rd(8'h08, 32'h0, "R3 restart reads 0");

        // R3 restart key, watchdog idle
        bus_wr(8'h08, 32'h0000_1234);
        bus_rd(8'h00, 32'h014F_B180, "R3 wrong key ignored");
        bus_wr(8'h08, 32'hABCD_4755);
        bus_rd(8'h00, 32'h1234_5678, "R3 key loads counter");

        // R6 tick mode
        bus_wr(8'h04, 32'd10);
        bus_wr(8'h0C, 32'h11);
        step(5);
        bus_rd(8'h00, 32'd10, "R6 no tick no step");
        tick_pulse(); tick_pulse(); tick_pulse();
        bus_rd(8'h00, 32'd7, "R6 three ticks");
        bus_wr(8'h08, 32'h0000_4755);
        bus_rd(8'h00, 32'd10, "R3 key reloads mid-count");
        bus_wr(8'h08, 32'h4755_0000);
        tick_pulse();
        bus_rd(8'h00, 32'd9, "R3 bad key ignored");

        // R5 stop on disable
        bus_wr(8'h0C, 32'h10);
        tick_pulse(); tick_pulse();
        bus_rd(8'h00, 32'd9, "R5 disabled ignores ticks");
        bus_wr(8'h04, 32'd100);
        bus_wr(8'h0C, 32'h0);
        bus_wr(8'h0C, 32'h1);
        step(3);
        bus_wr(8'h0C, 32'h0);
        step(5);
        bus_rd(8'h00, 32'd97, "R5 R11 clock mode stopped at 97");

        // R7 expiry with reset request, clock mode
        bus_wr(8'h04, 32'd5);
        bus_wr(8'h0C, 32'h3);
        step(4);
        check("R7 no request before zero", {31'b0, rst_req}, 32'h0);
        step(1);
        check("R7 request pulse", {31'b0, rst_req}, 32'h1);
        check("R7 sticky set", {31'b0, rst_sticky}, 32'h1);
        check("R8 irq off when bit2 clear", {31'b0, irq}, 32'h0);
        step(1);
        check("R7 request one cycle", {31'b0, rst_req}, 32'h0);
        check("R7 sticky holds", {31'b0, rst_sticky}, 32'h1);
        step(3);
        bus_rd(8'h00, 32'h0, "R7 counter saturates");

        // R4 and R8 interrupt only
        bus_wr(8'h0C, 32'h0);
        bus_wr(8'h0C, 32'h5);
        check("R4 rising edge clears sticky", {31'b0, rst_sticky}, 32'h0);
        step(4);
        check("R8 irq low before zero", {31'b0, irq}, 32'h0);
        step(1);
        check("R8 irq raised", {31'b0, irq}, 32'h1);
        check("R8 no request when bit1 clear", {31'b0, rst_req}, 32'h0);
        step(3);
        check("R8 irq level holds", {31'b0, irq}, 32'h1);

        // R9 bypass at expiry
        bus_wr(8'h0C, 32'h0);
        bus_wr(8'h04, 32'd4);
        mem_bypass = 1'b1;
        bus_wr(8'h0C, 32'h7);
        check("R4 rising edge clears irq", {31'b0, irq}, 32'h0);
        step(4);
        check("R9 no request", {31'b0, rst_req}, 32'h0);
        check("R9 no sticky", {31'b0, rst_sticky}, 32'h0);
        check("R9 no irq", {31'b0, irq}, 32'h0);
        bus_rd(8'h0C, 32'h0, "R9 control cleared");
        mem_bypass = 1'b0;

        step(3);
        check("monitor queue drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule